// File: doc/BRIEF.md
# System Reset and Soft-Off Control Port Block

This block sits on a simple I/O port bus and holds the three small registers that a host uses to reset the system, to put it into the soft-off sleep state, and to switch the interrupt-driven power management mode on and off. Each bus cycle presents an address, a read or write strobe and an access size. The block accepts a cycle only when the size fits the addressed register. It rejects every other cycle at one of its own addresses and marks it with an error strobe.

The reset register is one byte wide. A write with bit 2 set raises a one-cycle reset request. The 16-bit control register stores the sleep type in bits 12:10. Bit 13 is a write-only enable bit. Writing bit 13 together with sleep type 5 raises a one-cycle power-off request. Bit 0 of the control register shows the current power management mode. A control register write can never change that bit. Only the byte-wide, write-only command port changes it, through one enable code and one disable code. The mode is also driven out as a level for other logic.

Reads complete in one cycle. The value appears on the read data output in the cycle after the read strobe and stays there until the next accepted read. The actual reset sequencing, power sequencing and any sleep state other than soft-off are handled elsewhere.

Top module: `rsc_top`

## Requirements
- R1: The reset register at RST_ADDR accepts only byte accesses (io_size 0). A read returns the last byte written in bits 7:0, with bits 15:8 zero.
- R2: A byte write to the reset register with bit 2 set gives rst_req high for exactly the one cycle after the write, whatever bit 1 holds. A write with bit 2 clear gives no pulse.
- R3: The control register at CTL_ADDR accepts only 16-bit accesses (io_size 1). A read returns bits 12:2 as last written, the mode in bit 0, and zero in bits 15:13 and bit 1.
- R4: A write to the control register never changes the mode bit or acpi_en.
- R5: A control write with bit 13 set and bits 12:10 equal to 5 gives poff_req high for exactly the one cycle after the write. Any other sleep type, or bit 13 clear, gives no pulse.
- R6: A byte write to the command port at CMD_ADDR of CMD_ON sets acpi_en, and a write of CMD_OFF clears it. Any other value leaves acpi_en unchanged.
- R7: The following accesses are rejected: any access of the wrong size to one of the three addresses, a read of the command port, and a cycle with both strobes set. A rejected access changes no register and raises no request, and acc_err is high for exactly the one cycle after it.
- R8: After reset, acpi_en, rst_req, poff_req, acc_err and io_rdata are 0, and both readable registers read 0.
- R9: Read data appears on io_rdata in the cycle after an accepted read and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 double word |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| poff_req | output | 1 | One-cycle soft-off request |
| acpi_en | output | 1 | Power management mode level |
| acc_err | output | 1 | One-cycle rejected-access strobe |

## Verification
A wrong stored byte or control field shows up on io_rdata one cycle after the next read of that register. A corrupted mode bit shows up at once on acpi_en, and also in bit 0 of the next control read. A bad decode or a bad trigger condition shows up as a missing or extra rst_req, poff_req or acc_err pulse in the cycle right after the write. The bench therefore samples every pulse in that cycle, and again one cycle later to confirm that the pulse lasts a single cycle.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  localparam int unsigned DATA_W     = 16;
  localparam int unsigned SLP_LSB    = 10;
  localparam int unsigned SLP_W      = 3;
  localparam int unsigned SLP_EN_BIT = 13;

  // stored image of a control write: drops the enable bit, reserved bits and the mode bit
  function automatic logic [DATA_W-1:0] ctl_store(input logic [DATA_W-1:0] w);
    return {3'b000, w[12:2], 2'b00};
  endfunction

  // soft-off trigger: enable bit written together with the matching sleep type
  function automatic logic soft_off_hit(input logic [DATA_W-1:0] w,
                                        input logic [SLP_W-1:0] typ);
    return w[SLP_EN_BIT] && (w[SLP_LSB +: SLP_W] == typ);
  endfunction
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  RST_ADDR = 16'h0CF9,
  parameter logic [ADDR_W-1:0]  CTL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0]  CMD_ADDR = 16'h00B2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  io_size_e          size,
  output logic              rst_wr,
  output logic              rst_rd,
  output logic              ctl_wr,
  output logic              ctl_rd,
  output logic              cmd_wr,
  output logic              bad_acc,
  output logic              acc_err
);
  logic sel_rst, sel_ctl, sel_cmd, one_op, any_sel;
  logic rst_ok, ctl_ok, cmd_ok;

  always_comb begin
    sel_rst = (addr == RST_ADDR);
    sel_ctl = (addr == CTL_ADDR);
    sel_cmd = (addr == CMD_ADDR);
    one_op  = rd ^ wr;
    any_sel = (sel_rst || sel_ctl || sel_cmd) && (rd || wr);
    rst_ok  = sel_rst && one_op && (size == SZ_BYTE);
    ctl_ok  = sel_ctl && one_op && (size == SZ_WORD);
    cmd_ok  = sel_cmd && wr && !rd && (size == SZ_BYTE);
    rst_wr  = rst_ok && wr;
    rst_rd  = rst_ok && rd;
    ctl_wr  = ctl_ok && wr;
    ctl_rd  = ctl_ok && rd;
    cmd_wr  = cmd_ok;
    bad_acc = any_sel && !(rst_ok || ctl_ok || cmd_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= bad_acc;
  end

  p_onehot_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_wr, rst_rd, ctl_wr, ctl_rd, cmd_wr}));
  p_bad_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |-> !(rst_wr || rst_rd || ctl_wr || ctl_rd || cmd_wr));
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !bad_acc) |=> !acc_err);
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
#(
  parameter logic [7:0]       CMD_ON       = 8'hA0,
  parameter logic [7:0]       CMD_OFF      = 8'hA1,
  parameter logic [SLP_W-1:0] SOFT_OFF_TYP = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_wr,
  input  logic              ctl_wr,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        rst_val,
  output logic [DATA_W-1:0] ctl_val,
  output logic              sci_en,
  output logic              rst_req,
  output logic              poff_req
);
  logic [7:0]        rst_q;
  logic [DATA_W-1:0] ctl_q;
  logic              sci_q;
  logic              cmd_on_hit, cmd_off_hit, rst_fire, off_fire;

  always_comb begin
    cmd_on_hit  = cmd_wr && (wdata[7:0] == CMD_ON);
    cmd_off_hit = cmd_wr && (wdata[7:0] == CMD_OFF);
    rst_fire    = rst_wr && wdata[2];
    off_fire    = ctl_wr && soft_off_hit(wdata, SOFT_OFF_TYP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q    <= '0;
      ctl_q    <= '0;
      sci_q    <= 1'b0;
      rst_req  <= 1'b0;
      poff_req <= 1'b0;
    end else begin
      rst_req  <= rst_fire;
      poff_req <= off_fire;
      if (rst_wr) rst_q <= wdata[7:0];
      if (ctl_wr) ctl_q <= ctl_store(wdata);
      if (cmd_on_hit)       sci_q <= 1'b1;
      else if (cmd_off_hit) sci_q <= 1'b0;
    end
  end

  assign rst_val = rst_q;
  assign ctl_val = ctl_q | {{(DATA_W-1){1'b0}}, sci_q};
  assign sci_en  = sci_q;

  p_rst_req_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(rst_wr) && $past(wdata[2])));
  p_no_rst_bit2_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && !wdata[2]) |=> !rst_req);
  p_sci_hold_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (sci_q == $past(sci_q)));
  p_poff_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poff_req |-> ($past(ctl_wr) && $past(wdata[13]) && ($past(wdata[12:10]) == SOFT_OFF_TYP)));
  p_cmd_other_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (wdata[7:0] != CMD_ON) && (wdata[7:0] != CMD_OFF)) |=> $stable(sci_q));
  p_cmd_on_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (wdata[7:0] == CMD_ON)) |=> sci_q);
endmodule

// File: rtl/rsc_top.sv
module rsc_top
  import rsc_pkg::*;
#(
  parameter logic [15:0] RST_ADDR     = 16'h0CF9,
  parameter logic [15:0] CTL_ADDR     = 16'h0404,
  parameter logic [15:0] CMD_ADDR     = 16'h00B2,
  parameter logic [7:0]  CMD_ON       = 8'hA0,
  parameter logic [7:0]  CMD_OFF      = 8'hA1,
  parameter logic [2:0]  SOFT_OFF_TYP = 3'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [1:0]  io_size,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  output logic        rst_req,
  output logic        poff_req,
  output logic        acpi_en,
  output logic        acc_err
);
  logic              rst_wr, rst_rd, ctl_wr, ctl_rd, cmd_wr, bad_acc;
  logic [7:0]        rst_val;
  logic [DATA_W-1:0] ctl_val;
  logic [DATA_W-1:0] rdata_q;
  io_size_e          size_e;

  assign size_e = io_size_e'(io_size);

  rsc_decode #(
    .ADDR_W(16), .RST_ADDR(RST_ADDR), .CTL_ADDR(CTL_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(io_addr), .rd(io_rd), .wr(io_wr), .size(size_e),
    .rst_wr(rst_wr), .rst_rd(rst_rd), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .cmd_wr(cmd_wr), .bad_acc(bad_acc), .acc_err(acc_err)
  );

  rsc_regs #(
    .CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF), .SOFT_OFF_TYP(SOFT_OFF_TYP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .rst_wr(rst_wr), .ctl_wr(ctl_wr), .cmd_wr(cmd_wr),
    .wdata(io_wdata), .rst_val(rst_val), .ctl_val(ctl_val), .sci_en(acpi_en),
    .rst_req(rst_req), .poff_req(poff_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rst_rd) rdata_q <= {8'h00, rst_val};
    else if (ctl_rd) rdata_q <= ctl_val;
  end

  assign io_rdata = rdata_q;

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_rd || ctl_rd) |=> $stable(io_rdata));
  p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> !(rst_req || poff_req));
endmodule

// File: tb/test_rsc_top.sv
module test_rsc_top;
  localparam logic [15:0] RA = 16'h0CF9, CA = 16'h0404, MA = 16'h00B2;
  localparam logic [7:0]  ON = 8'hA0, OFF = 8'hA1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [1:0] io_size = '0;
  logic [15:0] io_rdata;
  logic rst_req, poff_req, acpi_en, acc_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rsc_top i_rsc_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .rst_req(rst_req), .poff_req(poff_req), .acpi_en(acpi_en), .acc_err(acc_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; returns at the negedge where its registered results are visible
  task automatic io(input logic rd, input logic wr, input logic [15:0] a,
                    input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_size = sz; io_wdata = d;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
  endtask

  function automatic logic [15:0] ctl_exp(input logic [15:0] w, input logic m);
    return (w & ~16'hE003) | {15'd0, m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 acpi_en", {15'd0, acpi_en}, 16'd0);
    chk("R8 pulses", {13'd0, rst_req, poff_req, acc_err}, 16'd0);
    chk("R8 rdata", io_rdata, 16'd0);
    io(1, 0, RA, 2'd0, 16'h0);
    chk("R8 reset reg", io_rdata, 16'd0);
    io(1, 0, CA, 2'd1, 16'h0);
    chk("R8 control reg", io_rdata, 16'd0);

    for (int v = 0; v < 256; v++) begin
      io(0, 1, RA, 2'd0, 16'(v) | 16'hAB00);
      chk("R2 rst_req pulse", {15'd0, rst_req}, {15'd0, v[2]});
      chk("R7 no err on good", {15'd0, acc_err}, 16'd0);
      io(1, 0, RA, 2'd0, 16'h0);
      chk("R2 single cycle", {15'd0, rst_req}, 16'd0);
      chk("R1 readback", io_rdata, {8'h00, 8'(v)});
    end

    for (int m = 0; m < 2; m++) begin
      if (m == 1) io(0, 1, MA, 2'd0, {8'h00, ON});
      for (int p = 0; p < 4; p++) begin
        for (int t = 0; t < 8; t++) begin
          for (int e = 0; e < 2; e++) begin
            logic [15:0] base, w;
            base = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'h5A5A : 16'hA5A5;
            w = (base & ~16'h3C00) | (16'(t) << 10) | (16'(e) << 13);
            io(0, 1, CA, 2'd1, w);
            chk("R5 poff pulse", {15'd0, poff_req}, {15'd0, (e == 1 && t == 5)});
            chk("R4 mode kept", {15'd0, acpi_en}, 16'(m));
            io(1, 0, CA, 2'd1, 16'h0);
            chk("R5 single cycle", {15'd0, poff_req}, 16'd0);
            chk("R3 readback", io_rdata, ctl_exp(w, m[0]));
          end
        end
      end
    end

    for (int v = 0; v < 256; v++) begin
      io(0, 1, MA, 2'd0, {8'h00, ON});
      io(0, 1, MA, 2'd0, 16'(v));
      chk("R6 from on", {15'd0, acpi_en}, {15'd0, (8'(v) != OFF)});
      io(0, 1, MA, 2'd0, {8'h00, OFF});
      io(0, 1, MA, 2'd0, 16'(v));
      chk("R6 from off", {15'd0, acpi_en}, {15'd0, (8'(v) == ON)});
    end

    // rejected accesses; mode is on here for the command checks
    io(0, 1, MA, 2'd0, {8'h00, ON});
    io(0, 1, RA, 2'd0, 16'h0011);
    io(0, 1, CA, 2'd1, 16'h0204);
    for (int s = 1; s < 4; s++) begin
      io(0, 1, RA, 2'(s), 16'h00FF);
      chk("R7 rst wrong size no pulse", {15'd0, rst_req}, 16'd0);
      chk("R7 rst wrong size err", {15'd0, acc_err}, 16'd1);
      io(1, 0, RA, 2'd0, 16'h0);
      chk("R7 err single cycle", {15'd0, acc_err}, 16'd0);
      chk("R7 rst unchanged", io_rdata, 16'h0011);
    end
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      io(0, 1, CA, 2'(s), 16'h3400);
      chk("R7 ctl wrong size no poff", {15'd0, poff_req}, 16'd0);
      chk("R7 ctl wrong size err", {15'd0, acc_err}, 16'd1);
      io(1, 0, CA, 2'd1, 16'h0);
      chk("R7 ctl unchanged", io_rdata, 16'h0205);
    end
    io(0, 1, MA, 2'd1, {8'h00, OFF});
    chk("R7 cmd wrong size err", {15'd0, acc_err}, 16'd1);
    chk("R7 cmd wrong size ignored", {15'd0, acpi_en}, 16'd1);
    io(1, 0, MA, 2'd0, 16'h0);
    chk("R7 cmd read err", {15'd0, acc_err}, 16'd1);
    io(1, 1, RA, 2'd0, 16'h0004);
    chk("R7 both strobes err", {15'd0, acc_err}, 16'd1);
    chk("R7 both strobes no pulse", {15'd0, rst_req}, 16'd0);

    io(1, 0, RA, 2'd0, 16'h0);
    chk("R9 read value", io_rdata, 16'h0011);
    io(0, 1, RA, 2'd0, 16'h0022);
    io(0, 1, CA, 2'd1, 16'h0008);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", io_rdata, 16'h0011);
    io(1, 0, CA, 2'd1, 16'h0);
    chk("R9 next read", io_rdata, 16'h0009);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule